// File: doc/BRIEF.md
# Flash Write-Completion Polling Engine

This block runs on the host side of an attached parallel flash. It decides when a program or erase that was already started on the flash has finished. A single start pulse captures four things: the location to watch, the word that was written, the detection method and whether the operation is a program or an erase. The engine then reads that location again and again through a simple request/acknowledge read port.

Two detection methods are offered. The first compares the top status bit (bit 7) of each read word with the expected value. The second watches bit 6 and treats it as settled when two reads in a row return the same value.

The flash finishes its write at a moment that has no relation to the host clock. A single read can therefore land on the transition and give a misleading result. For that reason, any apparent completion is confirmed by two further reads before the engine accepts it. If a confirmation read disagrees, the engine goes back to polling.

The engine reports the outcome with a one-cycle `done` pulse or a one-cycle `error` pulse. The `error` pulse means the read budget ran out. A count of the reads issued is also presented.

Top module: `pollEngine`

## Requirements
- R1: While `rstN` is low and after its release, `done`, `error` and `rdReq` are 0 and `pollCount` is 0.
- R2: A `start` pulse seen while the engine is idle captures `targetAddr`, `expectData`, `useToggle`, `isErase` and `pollLimit`. `rdAddr` then shows the captured address for the whole run. A `start` pulse seen while the engine is busy changes nothing.
- R3: A read completes on each clock edge at which `rdReq` and `rdAck` are both 1. `rdReq` stays high from the cycle after an accepted start until the outcome pulse. `pollCount` is cleared by an accepted start, rises by one for each completed read and holds its value after the run. It does not advance while `rdAck` is 0.
- R4: With `useToggle`=0 and `isErase`=0, a polling read suggests completion when its bit 7 equals bit 7 of the expected word.
- R5: With `useToggle`=0 and `isErase`=1, a polling read suggests completion when its bit 7 is 1.
- R6: With `useToggle`=1, a polling read suggests completion when its bit 6 equals bit 6 of the previous polling read. The first polling read after a start, and the first after a rejection, never suggests completion.
- R7: A suggested completion is followed by two confirmation reads of the same location. For a program, a confirmation read is valid only if the whole word equals the expected word. For an erase, it is valid only if every bit of the word is 1.
- R8: An invalid confirmation read ends the confirmation at once. Polling resumes, and the bit-6 history is discarded.
- R9: `done` is high for exactly one cycle, in the cycle after the second valid confirmation read. After that the engine is idle with `rdReq` low.
- R10: If the completed-read count reaches the captured limit and the read that reached it did not end with `done`, `error` is high for one cycle instead and the engine goes idle. A limit of 0 acts as 1. `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin watching a write; taken only when idle |
| targetAddr | input | AW | Location to poll |
| expectData | input | DW | Word written by the program operation |
| useToggle | input | 1 | 1 selects bit-6 toggle detection, 0 selects bit-7 data polling |
| isErase | input | 1 | 1 marks the operation as an erase |
| pollLimit | input | CW | Read budget before an error is reported |
| rdReq | output | 1 | Read request to the flash port |
| rdAddr | output | AW | Read address |
| rdAck | input | 1 | Read accepted; `rdData` valid in the same cycle |
| rdData | input | DW | Word returned by the flash |
| done | output | 1 | One-cycle pulse: completion confirmed |
| error | output | 1 | One-cycle pulse: read budget exhausted |
| pollCount | output | CW | Reads completed in the current or last run |

## Verification
Each method is driven with read streams of its own:
- **Data polling, program:** a stream whose bit 7 flips to the expected value, and a stream with a spurious bit-7 match whose full word is wrong. The second proves that a stray status bit is not taken for completion.
- **Data polling, erase:** a stream that rises to all ones.
- **Toggle detection:** a stream that alternates bit 6 before it settles.
- **Rejections:** one in the first confirmation read and one in the second. The read count at `done` shows that polling resumed and, in toggle mode, that the old bit-6 history was dropped.

Budget cases separate a limit hit during polling, a limit hit during confirmation, and a confirmation that ends exactly on the limit. A stalled acknowledge with a second `start` shows that the count freezes and that the captured settings cannot be disturbed.

// File: rtl/pollEnginePkg.sv
package pollEnginePkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_CONF1 = 2'd2,
    ST_CONF2 = 2'd3
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture start parameters, clear count and history
    logic take;       // a read completed this cycle
    logic inPoll;     // the completed read belongs to the polling phase
    logic clearHist;  // forget the bit-6 history
  } pollStrobe_t;

endpackage

// File: rtl/pollData.sv
module pollData #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pollEnginePkg::pollStrobe_t stb,
  input  logic [AW-1:0]              targetAddr,
  input  logic [DW-1:0]              expectData,
  input  logic                       useToggle,
  input  logic                       isErase,
  input  logic [CW-1:0]              pollLimit,
  input  logic [DW-1:0]              rdData,
  output logic [AW-1:0]              rdAddr,
  output logic [CW-1:0]              pollCount,
  output logic                       hit,
  output logic                       confOk,
  output logic                       lastRead
);

  localparam int STATUS_BIT = 7;
  localparam int TOGGLE_BIT = 6;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] expQ;
  logic          toggleQ;
  logic          eraseQ;
  logic [CW-1:0] limitQ;
  logic [CW-1:0] cntQ;
  logic          prevBit;
  logic          prevValid;
  logic [CW:0]   cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      expQ      <= '0;
      toggleQ   <= 1'b0;
      eraseQ    <= 1'b0;
      limitQ    <= ONE;
      cntQ      <= '0;
      prevBit   <= 1'b0;
      prevValid <= 1'b0;
    end else if (stb.load) begin
      addrQ     <= targetAddr;
      expQ      <= expectData;
      toggleQ   <= useToggle;
      eraseQ    <= isErase;
      limitQ    <= (pollLimit == '0) ? ONE : pollLimit;
      cntQ      <= '0;
      prevValid <= 1'b0;
    end else begin
      if (stb.take) cntQ <= cntQ + ONE;
      if (stb.clearHist) begin
        prevValid <= 1'b0;
      end else if (stb.take && stb.inPoll) begin
        prevBit   <= rdData[TOGGLE_BIT];
        prevValid <= 1'b1;
      end
    end
  end

  always_comb begin
    if (toggleQ)
      hit = prevValid && (rdData[TOGGLE_BIT] == prevBit);
    else if (eraseQ)
      hit = rdData[STATUS_BIT];
    else
      hit = (rdData[STATUS_BIT] == expQ[STATUS_BIT]);
  end

  assign confOk    = eraseQ ? (&rdData) : (rdData == expQ);
  assign cntNext   = {1'b0, cntQ} + {1'b0, ONE};
  assign lastRead  = (cntNext >= {1'b0, limitQ});
  assign rdAddr    = addrQ;
  assign pollCount = cntQ;

endmodule

// File: rtl/pollCtrl.sv
module pollCtrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       rdAck,
  input  logic                       hit,
  input  logic                       confOk,
  input  logic                       lastRead,
  output pollEnginePkg::pollStrobe_t stb,
  output logic                       rdReq,
  output logic                       done,
  output logic                       error
);
  import pollEnginePkg::*;

  pollState_t stateQ, stateD;
  logic doneD, errorD;

  assign rdReq = (stateQ != ST_IDLE);

  always_comb begin
    stateD        = stateQ;
    doneD         = 1'b0;
    errorD        = 1'b0;
    stb.load      = 1'b0;
    stb.take      = rdReq && rdAck;
    stb.inPoll    = (stateQ == ST_POLL);
    stb.clearHist = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateD   = ST_POLL;
        end
      end
      ST_POLL: begin
        if (stb.take) begin
          if (lastRead) begin
            errorD = 1'b1;
            stateD = ST_IDLE;
          end else if (hit) begin
            stateD = ST_CONF1;
          end
        end
      end
      ST_CONF1: begin
        if (stb.take) begin
          if (!confOk) stb.clearHist = 1'b1;
          if (lastRead) begin
            errorD = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stateD = confOk ? ST_CONF2 : ST_POLL;
          end
        end
      end
      ST_CONF2: begin
        if (stb.take) begin
          if (confOk) begin
            doneD  = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stb.clearHist = 1'b1;
            errorD = lastRead;
            stateD = lastRead ? ST_IDLE : ST_POLL;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= doneD;
      error  <= errorD;
    end
  end

endmodule

// File: rtl/pollEngine.sv
module pollEngine #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] targetAddr,
  input  logic [DW-1:0] expectData,
  input  logic          useToggle,
  input  logic          isErase,
  input  logic [CW-1:0] pollLimit,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic          rdAck,
  input  logic [DW-1:0] rdData,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] pollCount
);

  pollEnginePkg::pollStrobe_t stb;
  logic hit, confOk, lastRead;

  pollCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck),
    .hit(hit), .confOk(confOk), .lastRead(lastRead),
    .stb(stb), .rdReq(rdReq), .done(done), .error(error)
  );

  pollData #(.AW(AW), .DW(DW), .CW(CW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .targetAddr(targetAddr), .expectData(expectData),
    .useToggle(useToggle), .isErase(isErase), .pollLimit(pollLimit),
    .rdData(rdData), .rdAddr(rdAddr), .pollCount(pollCount),
    .hit(hit), .confOk(confOk), .lastRead(lastRead)
  );

endmodule

// File: rtl/pollEngineChk.sv
module pollEngineChk #(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdReq,
  input logic          rdAck,
  input logic [AW-1:0] rdAddr,
  input logic          done,
  input logic          error,
  input logic [CW-1:0] pollCount
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_outcome_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_req_ends_with_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdReq) |-> (done || error));

  assert_idle_after_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !rdReq);

  assert_count_frozen_on_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> $stable(pollCount));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && $past(rdReq)) |-> $stable(rdAddr));

  assert_error_after_reads_R10: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (pollCount != '0));

endmodule

bind pollEngine pollEngineChk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAck(rdAck), .rdAddr(rdAddr),
  .done(done), .error(error), .pollCount(pollCount)
);

// File: tb/test_pollEngine.sv
module test_pollEngine;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic              tog;
    logic              ers;
    logic [15:0]       exp;
    logic [15:0]       lim;
    logic [0:7][15:0]  scr;
    logic              expDone;
    logic [15:0]       expCnt;
  } caseVec_t;

  localparam int NCASE = 9;
  localparam caseVec_t CASES [NCASE] = '{
    // R4 program, bit 7 settles then two full matches
    '{1'b0, 1'b0, 16'h00A5, 16'd20, '{16'h0025,16'h0025,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5}, 1'b1, 16'd5},
    // R7 R8 spurious bit-7 match rejected in first confirmation
    '{1'b0, 1'b0, 16'h00A5, 16'd20, '{16'h0080,16'h0080,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5}, 1'b1, 16'd5},
    // R5 erase polls for bit 7 high and all-ones word
    '{1'b0, 1'b1, 16'h0000, 16'd20, '{16'h0000,16'h0040,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF}, 1'b1, 16'd5},
    // R6 toggle program: bit 6 alternates then settles
    '{1'b1, 1'b0, 16'h1234, 16'd20, '{16'h0040,16'h0000,16'h0040,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234}, 1'b1, 16'd7},
    // R10 budget of 4 runs out during polling
    '{1'b0, 1'b0, 16'h00A5, 16'd4,  '{16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}, 1'b0, 16'd4},
    // R8 rejection in second confirmation, polling resumes
    '{1'b0, 1'b0, 16'h00A5, 16'd10, '{16'h00A5,16'h00A5,16'h0085,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5}, 1'b1, 16'd6},
    // R8 R6 toggle erase: history dropped after rejection
    '{1'b1, 1'b1, 16'h0000, 16'd20, '{16'hFFFF,16'hFFFF,16'h00BF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF}, 1'b1, 16'd7},
    // R10 budget of 2 ends inside confirmation
    '{1'b0, 1'b0, 16'h00A5, 16'd2,  '{16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5}, 1'b0, 16'd2},
    // R10 R9 confirmation ends exactly on the budget: done wins
    '{1'b0, 1'b0, 16'h00A5, 16'd3,  '{16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5,16'h00A5}, 1'b1, 16'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] targetAddr = '0;
  logic [DW-1:0] expectData = '0;
  logic useToggle = 1'b0;
  logic isErase = 1'b0;
  logic [CW-1:0] pollLimit = '0;
  logic rdReq;
  logic [AW-1:0] rdAddr;
  logic rdAck = 1'b1;
  logic [DW-1:0] rdData;
  logic done, error;
  logic [CW-1:0] pollCount;

  logic [0:7][15:0] curScr = '0;
  logic idxClr = 1'b0;
  int   idx = 0;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  always #10 clk = ~clk;

  assign rdData = curScr[idx];

  always @(posedge clk) begin
    if (idxClr) idx <= 0;
    else if (rdReq && rdAck && idx < 7) idx <= idx + 1;
  end

  pollEngine #(.AW(AW), .DW(DW), .CW(CW)) i_pollEngine (
    .clk(clk), .rstN(rstN), .start(start), .targetAddr(targetAddr),
    .expectData(expectData), .useToggle(useToggle), .isErase(isErase),
    .pollLimit(pollLimit), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdData(rdData), .done(done), .error(error), .pollCount(pollCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic waitOutcome(input caseVec_t c, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 80 && !seen; k++) begin
      if (done || error) seen = 1'b1;
      else @(negedge clk);
    end
    chk(done == c.expDone, {tag, " done"}, int'(done), int'(c.expDone));
    chk(error == !c.expDone, {tag, " error"}, int'(error), int'(!c.expDone));
    chk(pollCount == c.expCnt, {tag, " count"}, int'(pollCount), int'(c.expCnt));
    @(negedge clk);
    chk(!done && !error && !rdReq, "R9 single pulse then idle", int'({done, error, rdReq}), 0);
    chk(pollCount == c.expCnt, "R3 count holds", int'(pollCount), int'(c.expCnt));
  endtask

  task automatic launch(input caseVec_t c, input logic [AW-1:0] a);
    @(negedge clk);
    curScr = c.scr;
    idxClr = 1'b1;
    @(negedge clk);
    idxClr = 1'b0;
    start = 1'b1;
    targetAddr = a;
    expectData = c.exp;
    useToggle = c.tog;
    isErase = c.ers;
    pollLimit = c.lim;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done && !error && !rdReq && pollCount == 0, "R1 in reset", int'({done, error, rdReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !error && !rdReq && pollCount == 0, "R1 after reset", int'(pollCount), 0);

    for (int i = 0; i < NCASE; i++) begin
      launch(CASES[i], AW'(20'h05000 + i));
      chk(rdReq && rdAddr == AW'(20'h05000 + i), "R2 address presented", int'(rdAddr), 20'h05000 + i);
      waitOutcome(CASES[i], $sformatf("R4-R10 case %0d", i));
    end

    // R2 R3 stalled acknowledge, second start ignored
    rdAck = 1'b0;
    launch(CASES[0], 20'h0ABCD);
    repeat (3) @(negedge clk);
    chk(pollCount == 0, "R3 no advance while stalled", int'(pollCount), 0);
    chk(rdReq == 1'b1, "R3 request held", int'(rdReq), 1);
    start = 1'b1;
    targetAddr = 20'h01111;
    useToggle = 1'b1;
    expectData = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(rdAddr == 20'h0ABCD, "R2 start while busy ignored", int'(rdAddr), 20'h0ABCD);
    rdAck = 1'b1;
    waitOutcome(CASES[0], "R2 busy start ignored");

    // R10 limit 0 acts as 1
    begin
      caseVec_t z = CASES[4];
      z.lim = 16'd0;
      z.expCnt = 16'd1;
      launch(z, 20'h00777);
      waitOutcome(z, "R10 zero limit");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule